// File: doc/BRIEF.md
# Packed Float-to-Fixed Lane Converter

This unit takes a 32-bit instruction word and a 128-bit packed operand, and turns each IEEE 754 floating-point lane of the operand into a fixed-point integer. Lanes may be half, single or double precision. A single 7-bit immediate in the instruction gives both the lane size and the position of the binary point. The unit multiplies each lane by two to the power of the fraction-bit count. It then truncates toward zero and writes the integer into the lane of the same width. The conversion is signed or unsigned as the instruction selects.

Two forms share the converter. The vector form works on the low 64 bits or on all 128 bits. The scalar form converts lane 0 only. In the scalar form, the bits above that lane either keep the old destination value or are cleared, which follows the merge control. Results are registered. They appear on the clock edge after `issue` and hold until the next issue. Invalid and inexact flags accumulate until reset. An undefined encoding sets the undefined flag and leaves the result and both flags as they were.

Top module: `fp_fix_conv`

## Requirements
- R1: A word is accepted only if bit 31 is 0 and bits 15:10 are all ones. Bits 28:23 must also be `111110` with bit 30 set (scalar form) or `011110` (vector form). Any other word sets `undef`.
- R2: The lane size comes from bits 22:19. A pattern of `1xxx` gives 64-bit lanes, `01xx` gives 32-bit lanes and `001x` gives 16-bit lanes. The fraction-bit count is twice the lane width minus the unsigned value of bits 22:16.
- R3: In vector form, bit 30 set converts every lane of the 128-bit operand. With bit 30 clear, only the lanes in the low 64 bits are converted and result bits 127:64 are zero.
- R4: The word is undefined if bits 22:19 are `000x`, if they are `001x` while `fp16_en` is low, or if the vector form has bit 22 set and bit 30 clear. An undefined word sets `undef` and leaves `result`, `invalid` and `inexact` unchanged.
- R5: When bit 29 is 0, each lane becomes a two's complement integer equal to the lane value times 2^fbits, truncated toward zero.
- R6: When bit 29 is 1, the output is unsigned. A negative lane whose scaled value truncates to a nonzero magnitude gives 0 and raises invalid. A negative lane that truncates to zero gives 0 without raising invalid.
- R7: A NaN lane gives 0 and raises invalid. An infinity, or a scaled value outside the output range, saturates to the largest or smallest code and raises invalid. `invalid` stays set until reset.
- R8: A valid lane that discards nonzero fraction bits raises `inexact`. A lane that raises invalid does not also raise inexact. `inexact` stays set until reset.
- R9: The scalar form converts lane 0 only. With `merge_en` high, the bits above that lane come from `old_dst`. With `merge_en` low, those bits are zero.
- R10: The result and flags of an issued word appear one clock edge after `issue`. While `issue` is low, all outputs hold.
- R11: After reset, `result` is zero and `undef`, `invalid` and `inexact` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | Applies the instruction on this edge |
| instr | input | 32 | Instruction word |
| src | input | 128 | Packed floating-point operand |
| old_dst | input | 128 | Previous destination contents, used in scalar merge |
| fp16_en | input | 1 | Half-precision lanes permitted |
| merge_en | input | 1 | Scalar form keeps the upper destination bits |
| result | output | 128 | Packed fixed-point result |
| undef | output | 1 | Last issued word was undefined |
| invalid | output | 1 | Sticky invalid-operation flag |
| inexact | output | 1 | Sticky inexact flag |

## Verification
Every fault in decode or conversion reaches the port one edge after `issue`, because the result register is the only state apart from the two sticky flags. A wrong lane-size or fraction-bit decode corrupts every lane of that issue, so one mismatch shows it. A wrong saturation or shift edge appears only for particular encodings. For that reason all 65536 half-precision encodings are swept, and single and double lanes get exponents steered near the range limits. The flags are checked after a reset before each operation, so one operation that wrongly sets a flag cannot hide behind an earlier correct one.

// File: rtl/fxcvt_pkg.sv
package fxcvt_pkg;
    localparam int VEC_BITS   = 128;
    localparam int INSTR_BITS = 32;
    localparam int IMM_BITS   = 7;

    typedef enum logic [1:0] {
        LANE_H = 2'd0,
        LANE_S = 2'd1,
        LANE_D = 2'd2
    } lane_sz_e;

    typedef struct packed {
        logic                undef;
        logic                scalar;
        logic                q;
        logic                uns;
        lane_sz_e            sz;
        logic [IMM_BITS-1:0] fbits;
    } dec_t;
endpackage

// File: rtl/fxcvt_decode.sv
module fxcvt_decode
    import fxcvt_pkg::*;
(
    input  logic [INSTR_BITS-1:0] instr,
    input  logic                  fp16_en,
    output dec_t                  dec
);
    logic [3:0]          hi_imm;
    logic [IMM_BITS-1:0] imm;
    logic [7:0]          twice_w;
    logic [7:0]          fb_wide;
    logic                is_scalar;
    logic                is_vector;
    logic                unused_fields;

    assign unused_fields = ^instr[9:0];

    always_comb begin
        hi_imm    = instr[22:19];
        imm       = instr[22:16];
        is_scalar = (instr[28:23] == 6'b111110) && instr[30];
        is_vector = (instr[28:23] == 6'b011110);

        dec.scalar = is_scalar;
        dec.q      = instr[30];
        dec.uns    = instr[29];

        if (hi_imm[3])      dec.sz = LANE_D;
        else if (hi_imm[2]) dec.sz = LANE_S;
        else                dec.sz = LANE_H;

        unique case (dec.sz)
            LANE_D:  twice_w = 8'd128;
            LANE_S:  twice_w = 8'd64;
            default: twice_w = 8'd32;
        endcase
        fb_wide   = twice_w - {1'b0, imm};
        dec.fbits = fb_wide[IMM_BITS-1:0];

        dec.undef = instr[31] || (instr[15:10] != 6'b111111)
                 || !(is_scalar || is_vector)
                 || (hi_imm[3:1] == 3'b000)
                 || ((hi_imm[3:2] == 2'b00) && !fp16_en)
                 || (is_vector && hi_imm[3] && !instr[30]);
    end
endmodule

// File: rtl/fxcvt_lane.sv
module fxcvt_lane #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W+MAN_W:0] op,
    input  logic [6:0]           fbits,
    input  logic                 uns,
    output logic [EXP_W+MAN_W:0] res,
    output logic                 nv,
    output logic                 nx
);
    localparam int W     = EXP_W + MAN_W + 1;
    localparam int SIG_W = MAN_W + 1;
    localparam int WIDE  = W + SIG_W + 1;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

    logic             sgn, is_nan, is_inf, big, dropped;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mn;
    logic [SIG_W-1:0] sig;
    logic [15:0]      ex_eff, shamt, rsh;
    logic [WIDE-1:0]  mag, lim;
    logic [W-1:0]     sat;

    always_comb begin
        sgn    = op[W-1];
        ex     = op[W-2:MAN_W];
        mn     = op[MAN_W-1:0];
        sig    = {|ex, mn};
        is_nan = (&ex) && (|mn);
        is_inf = (&ex) && !(|mn);
        ex_eff = (ex == '0) ? 16'd1 : 16'(ex);
        shamt  = ex_eff + 16'(fbits) - 16'(BIAS + MAN_W);
        rsh    = -shamt;
        mag    = '0;
        dropped = 1'b0;
        big    = 1'b0;
        if (!shamt[15]) begin
            if (shamt > 16'(W)) big = 1'b1;
            else                mag = WIDE'(sig) << shamt[7:0];
        end else if (rsh >= 16'(SIG_W)) begin
            dropped = |sig;
        end else begin
            mag     = WIDE'(sig >> rsh);
            dropped = |(sig & ~({SIG_W{1'b1}} << rsh));
        end

        if (uns)      lim = WIDE'({W{1'b1}});
        else if (sgn) lim = WIDE'(1) << (W - 1);
        else          lim = WIDE'({(W-1){1'b1}});

        if (uns)      sat = sgn ? '0 : {W{1'b1}};
        else          sat = sgn ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

        res = '0;
        nv  = 1'b0;
        nx  = 1'b0;
        if (is_nan) begin
            nv = 1'b1;
        end else if (is_inf || big || (mag > lim)) begin
            nv  = 1'b1;
            res = sat;
        end else if (uns && sgn && (mag != '0)) begin
            nv = 1'b1;
        end else begin
            res = sgn ? W'(-mag) : W'(mag);
            nx  = dropped;
        end
    end
endmodule

// File: rtl/fxcvt_bank.sv
module fxcvt_bank #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10,
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]                     src,
    input  logic [6:0]                           fbits,
    input  logic                                 uns,
    output logic [VEC_W-1:0]                     res,
    output logic [VEC_W/(EXP_W+MAN_W+1)-1:0]     nv,
    output logic [VEC_W/(EXP_W+MAN_W+1)-1:0]     nx
);
    localparam int LW = EXP_W + MAN_W + 1;
    localparam int N  = VEC_W / LW;

    for (genvar g = 0; g < N; g++) begin : g_lane
        fxcvt_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_lane (
            .op    (src[g*LW +: LW]),
            .fbits (fbits),
            .uns   (uns),
            .res   (res[g*LW +: LW]),
            .nv    (nv[g]),
            .nx    (nx[g])
        );
    end
endmodule

// File: rtl/fp_fix_conv.sv
module fp_fix_conv
    import fxcvt_pkg::*;
#(
    parameter int VEC_W = VEC_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [INSTR_BITS-1:0] instr,
    input  logic [VEC_W-1:0]      src,
    input  logic [VEC_W-1:0]      old_dst,
    input  logic                  fp16_en,
    input  logic                  merge_en,
    output logic [VEC_W-1:0]      result,
    output logic                  undef,
    output logic                  invalid,
    output logic                  inexact
);
    localparam int NH = VEC_W / 16;
    localparam int NS = VEC_W / 32;
    localparam int ND = VEC_W / 64;

    typedef struct packed {
        logic [VEC_W-1:0] result;
        logic             undef;
        logic             inv;
        logic             inx;
    } st_t;

    st_t st_d, st_q;
    dec_t dec;
    logic [VEC_W-1:0] h_res, s_res, d_res, base;
    logic [NH-1:0]    h_nv, h_nx;
    logic [NS-1:0]    s_nv, s_nx;
    logic [ND-1:0]    d_nv, d_nx;
    logic             nv_any, nx_any;

    fxcvt_decode u_dec (.instr(instr), .fp16_en(fp16_en), .dec(dec));

    fxcvt_bank #(.EXP_W(5),  .MAN_W(10), .VEC_W(VEC_W)) u_half (
        .src(src), .fbits(dec.fbits), .uns(dec.uns), .res(h_res), .nv(h_nv), .nx(h_nx));
    fxcvt_bank #(.EXP_W(8),  .MAN_W(23), .VEC_W(VEC_W)) u_single (
        .src(src), .fbits(dec.fbits), .uns(dec.uns), .res(s_res), .nv(s_nv), .nx(s_nx));
    fxcvt_bank #(.EXP_W(11), .MAN_W(52), .VEC_W(VEC_W)) u_double (
        .src(src), .fbits(dec.fbits), .uns(dec.uns), .res(d_res), .nv(d_nv), .nx(d_nx));

    function automatic logic lane_on(input int i, input int n, input logic sc, input logic q);
        return sc ? (i == 0) : (q || (i < n / 2));
    endfunction

    always_comb begin
        st_d   = st_q;
        nv_any = 1'b0;
        nx_any = 1'b0;
        base   = (dec.scalar && merge_en) ? old_dst : '0;
        unique case (dec.sz)
            LANE_H: for (int i = 0; i < NH; i++)
                if (lane_on(i, NH, dec.scalar, dec.q)) begin
                    base[i*16 +: 16] = h_res[i*16 +: 16];
                    nv_any = nv_any | h_nv[i];
                    nx_any = nx_any | h_nx[i];
                end
            LANE_S: for (int i = 0; i < NS; i++)
                if (lane_on(i, NS, dec.scalar, dec.q)) begin
                    base[i*32 +: 32] = s_res[i*32 +: 32];
                    nv_any = nv_any | s_nv[i];
                    nx_any = nx_any | s_nx[i];
                end
            LANE_D: for (int i = 0; i < ND; i++)
                if (lane_on(i, ND, dec.scalar, dec.q)) begin
                    base[i*64 +: 64] = d_res[i*64 +: 64];
                    nv_any = nv_any | d_nv[i];
                    nx_any = nx_any | d_nx[i];
                end
            default: ;
        endcase
        if (issue) begin
            st_d.undef = dec.undef;
            if (!dec.undef) begin
                st_d.result = base;
                st_d.inv    = st_q.inv | nv_any;
                st_d.inx    = st_q.inx | nx_any;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result  = st_q.result;
    assign undef   = st_q.undef;
    assign invalid = st_q.inv;
    assign inexact = st_q.inx;

    p_undef_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue && dec.undef |=> $stable(result) && $stable(invalid) && $stable(inexact) && undef);
    p_sticky_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |=> invalid);
    p_sticky_inx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inexact |=> inexact);
    p_low_half_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !dec.undef && !dec.scalar && !dec.q |=> result[VEC_W-1:VEC_W/2] == '0);
    p_scalar_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !dec.undef && dec.scalar && !merge_en |=> result[VEC_W-1:64] == '0);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(result) && $stable(undef));
endmodule

// File: tb/fp_fix_conv_test.sv
`timescale 1ns/1ps
module fp_fix_conv_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src = '0;
    logic [127:0] old_dst = '0;
    logic         fp16_en = 1'b1;
    logic         merge_en = 1'b0;
    logic [127:0] result;
    logic         undef, invalid, inexact;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fp_fix_conv uut (.clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr), .src(src),
        .old_dst(old_dst), .fp16_en(fp16_en), .merge_en(merge_en), .result(result),
        .undef(undef), .invalid(invalid), .inexact(inexact));

    function automatic logic [31:0] mk(input bit sc, input bit q, input bit u, input int imm, input bit b10);
        return {1'b0, sc ? 1'b1 : q, u, sc ? 6'b111110 : 6'b011110, 7'(imm), 5'b11111, b10, 10'h041};
    endfunction

    function automatic void ref_lane(input logic [63:0] b, input int ew, input int mw, input int fb,
                                     input bit uns, output logic [63:0] r, output bit nv, output bit nx,
                                     output bit sat);
        int w = 1 + ew + mw;
        int bias = (1 << (ew - 1)) - 1;
        longint unsigned ex = (b >> mw) & ((64'd1 << ew) - 1);
        longint unsigned mn = b & ((64'd1 << mw) - 1);
        bit sg = b[w-1];
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        real v, t, two63;
        logic [63:0] m;
        bit over;
        two63 = $pow(2.0, 63);
        r = '0; nv = 0; nx = 0; sat = 0;
        if (ex == (64'd1 << ew) - 1 && mn != 0) begin nv = 1; sat = 1; return; end
        if (ex == (64'd1 << ew) - 1) begin
            over = 1;
            t = 0.0; v = 0.0;
        end else begin
            v = ((ex == 0) ? real'(mn) : real'(mn) + $pow(2.0, mw))
                * $pow(2.0, ((ex == 0) ? 1 : int'(ex)) - bias - mw + fb);
            t = $floor(v);
            if (uns) over = !sg && t >= $pow(2.0, w);
            else     over = sg ? (t > $pow(2.0, w - 1)) : (t >= $pow(2.0, w - 1));
        end
        if (over) begin
            nv = 1; sat = 1;
            if (uns) r = sg ? '0 : mask;
            else     r = sg ? (64'd1 << (w - 1)) : (mask >> 1);
        end else if (uns && sg && t != 0.0) begin
            nv = 1;
        end else begin
            if (t >= two63) m = 64'h8000_0000_0000_0000 | 64'(longint'(t - two63));
            else            m = 64'(longint'(t));
            r  = (sg ? -m : m) & mask;
            nx = (v != t);
        end
    endfunction

    task automatic expect_op(input bit sc, input bit q, input bit u, input int esz, input int fb,
                             input logic [127:0] s, input logic [127:0] old, input bit mg,
                             output logic [127:0] r, output bit nv, output bit nx, output string tag);
        int n = sc ? 1 : (q ? 128 / esz : 64 / esz);
        int ew = (esz == 16) ? 5 : (esz == 32) ? 8 : 11;
        int mw = esz - 1 - ew;
        logic [127:0] lmask = (esz == 64) ? {64'd0, 64'hFFFF_FFFF_FFFF_FFFF} : ((128'd1 << esz) - 1);
        bit any_sat = 0, any_nv = 0;
        r = (sc && mg) ? old : '0;
        nv = 0; nx = 0;
        for (int i = 0; i < n; i++) begin
            logic [63:0] lr; bit lnv, lnx, lsat;
            ref_lane(64'((s >> (i * esz)) & lmask), ew, mw, fb, u, lr, lnv, lnx, lsat);
            r = (r & ~(lmask << (i * esz))) | ((128'(lr) & lmask) << (i * esz));
            nv |= lnv; nx |= lnx; any_sat |= lsat; any_nv |= lnv;
        end
        if (any_sat)     tag = "R7";
        else if (any_nv) tag = "R6";
        else if (sc)     tag = "R9";
        else             tag = "R5";
    endtask

    task automatic apply(input logic [31:0] w, input logic [127:0] s, input bit do_reset);
        @(negedge clk);
        if (do_reset) begin
            rst_n = 0; issue = 0;
            @(negedge clk);
            rst_n = 1;
        end
        instr = w; src = s; issue = 1;
        @(negedge clk);
        issue = 0;
    endtask

    task automatic check(input string tag, input logic [127:0] er, input bit eu, input bit ev, input bit ex);
        checks++;
        if (result !== er || undef !== eu || invalid !== ev || inexact !== ex) begin
            errors++;
            $display("FAIL %s: got res=%h u=%b nv=%b nx=%b exp res=%h u=%b nv=%b nx=%b",
                     tag, result, undef, invalid, inexact, er, eu, ev, ex);
        end
    endtask

    task automatic run_conv(input bit sc, input bit q, input bit u, input int esz, input int fb,
                            input logic [127:0] s);
        logic [127:0] er; bit ev, ex; string tag;
        expect_op(sc, q, u, esz, fb, s, old_dst, merge_en, er, ev, ex, tag);
        apply(mk(sc, q, u, 2 * esz - fb, 1'b1), s, 1'b1);
        check(tag, er, 1'b0, ev, ex);
    endtask

    function automatic logic [63:0] rnd_lane(input int esz);
        logic [63:0] v = {$urandom, $urandom};
        int ew = (esz == 16) ? 5 : (esz == 32) ? 8 : 11;
        int mw = esz - 1 - ew;
        int bias = (1 << (ew - 1)) - 1;
        if ($urandom % 4 != 0) begin
            logic [63:0] e = 64'(bias - 8 + int'($urandom % (esz + 12)));
            v = (v & ~(((64'd1 << ew) - 1) << mw)) | (e << mw);
        end
        return v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] er, held; bit ev, ex; string tag;
        void'($urandom(7));
        @(negedge clk);
        @(negedge clk);
        check("R11", '0, 0, 0, 0);
        rst_n = 1;

        // R2 R5 R6 R7 R8: every half encoding, fbits and signedness varied per operation
        for (int k = 0; k < 8192; k++) begin
            logic [127:0] s;
            for (int i = 0; i < 8; i++) s[i*16 +: 16] = 16'(8 * k + i);
            run_conv(0, 1, k[4], 16, 1 + (k % 16), s);
        end
        // single lanes, vector 64/128 and scalar forms
        for (int k = 0; k < 1500; k++) begin
            logic [127:0] s;
            bit sc = (k % 4 == 3);
            for (int i = 0; i < 4; i++) s[i*32 +: 32] = rnd_lane(32)[31:0];
            old_dst = {$urandom, $urandom, $urandom, $urandom};
            merge_en = k[3];
            run_conv(sc, k[1], k[2], 32, 1 + int'($urandom % 32), s);
        end
        // double lanes
        for (int k = 0; k < 1500; k++) begin
            logic [127:0] s;
            bit sc = (k % 4 == 3);
            s = {rnd_lane(64), rnd_lane(64)};
            old_dst = {$urandom, $urandom, $urandom, $urandom};
            merge_en = k[3];
            run_conv(sc, 1, k[2], 64, 1 + int'($urandom % 64), s);
        end

        // R5: 1.5 with one fraction bit gives 3, exact
        merge_en = 0;
        run_conv(0, 1, 0, 64, 1, {64'h3FF8_0000_0000_0000, 64'hBFF8_0000_0000_0000});
        // R8: 2.75 with one fraction bit gives 5 and inexact
        apply(mk(0, 1, 0, 127, 1), {64'h0, 64'h4006_0000_0000_0000}, 1);
        check("R8", {64'h0, 64'd5}, 0, 0, 1);
        held = result;
        // R4: reserved lane-size code, result and flags held
        apply(mk(0, 1, 0, 8'h0F, 1), {4{32'h4000_0000}}, 0);
        check("R4", held, 1, 0, 1);
        // R4: half lanes with half precision disabled
        fp16_en = 0;
        apply(mk(0, 1, 0, 30, 1), {8{16'h3C00}}, 0);
        check("R4", held, 1, 0, 1);
        fp16_en = 1;
        // R4: double lanes with the 64-bit operand
        apply(mk(0, 0, 0, 127, 1), {2{64'h3FF0_0000_0000_0000}}, 0);
        check("R4", held, 1, 0, 1);
        // R1: fixed bit 10 cleared
        apply(mk(0, 1, 0, 63, 0), {4{32'h3F80_0000}}, 0);
        check("R1", held, 1, 0, 1);
        // R3: 64-bit vector of singles clears the upper half
        apply(mk(0, 0, 0, 63, 1), {4{32'h3F80_0000}}, 1);
        check("R3", {64'h0, 32'd2, 32'd2}, 0, 0, 0);
        // R9: scalar with merge keeps old bits above lane 0
        old_dst = {4{32'hA5A5_A5A5}}; merge_en = 1;
        apply(mk(1, 0, 0, 63, 1), {4{32'h4040_0000}}, 1);
        check("R9", {{3{32'hA5A5_A5A5}}, 32'd6}, 0, 0, 0);
        // R9: scalar without merge clears them
        merge_en = 0;
        apply(mk(1, 0, 0, 63, 1), {4{32'h4040_0000}}, 1);
        check("R9", {96'h0, 32'd6}, 0, 0, 0);
        // R10: no issue, new operand has no effect on outputs
        @(negedge clk);
        src = {4{32'hC2C8_0000}}; instr = mk(0, 1, 0, 63, 1);
        @(negedge clk);
        @(negedge clk);
        check("R10", {96'h0, 32'd6}, 0, 0, 0);
        // R7: NaN lane, then a clean operation keeps invalid set
        apply(mk(0, 1, 0, 63, 1), {96'h0, 32'h7FC0_0000}, 1);
        check("R7", '0, 0, 1, 0);
        apply(mk(0, 1, 0, 63, 1), {4{32'h3F80_0000}}, 0);
        check("R7", {4{32'd2}}, 0, 1, 0);
        // R6: unsigned -0.25 with one fraction bit truncates to zero without invalid
        expect_op(0, 1, 1, 32, 1, {4{32'hBE80_0000}}, '0, 0, er, ev, ex, tag);
        apply(mk(0, 1, 1, 63, 1), {4{32'hBE80_0000}}, 1);
        check("R6", er, 0, ev, ex);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule